// File: doc/BRIEF.md
# Crosspoint Routing Configuration Receiver (Write-Only Two-Wire Slave)

This block is the configuration front end of a 12-input, 9-output video routing matrix. It watches a two-wire I2C bus in Standard mode, sampling both lines with a fast system clock. When it sees its own device address with a write direction, it accepts a register pointer byte and then any number of data bytes. Each data byte goes to the register the pointer names, and the pointer then steps by one. The block drives the bus only to acknowledge bytes. It has no read path and never stretches the clock.

The stored registers are decoded for each output into an enable, a two-bit gain code and a one-hot input selection. A 12-bit vector gives the clamp or bias mode of each input. The matrix datapath uses these signals directly. Writes to pointers that name no register are acknowledged and then dropped. Clearing an output's enable bit removes its input selection, whatever the select field holds.

Top module: `xbar_cfg_slave`

## Requirements
- R1: After a synchronous active-low reset, every stored register is 0. All enables, gains, one-hot selects and clamp bits read 0, and the acknowledge pull output is 0.
- R2: The slave responds to the address byte 0x06 when `addr_sel_i` is 0 and to 0x86 when it is 1 (bit 0 = 0 means write). It acknowledges that byte, the pointer byte and every data byte by holding `sda_pull_o` high (SDA low) through the high phase of the ninth SCL clock.
- R3: An address byte that does not match, including a matching address with bit 0 = 1, gets no acknowledge. Until the next START, no later byte is acknowledged and no register changes.
- R4: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START in the middle of a transfer begins a new address phase. Bytes clocked after a STOP with no new START are neither acknowledged nor written.
- R5: Pointers 0x01 to 0x09 hold the control of outputs 0 to 8. Bit 7 is the enable, which appears on `out_en_o[k]`. Bits 6:5 are the gain code (00 = 6 dB, 01 = 7 dB, 10 = 8 dB, 11 = 9 dB), which appears on `out_gain_o[2k+1:2k]`. Bits 4:0 are the input select.
- R6: A select value v in 1..12 on an enabled output sets only bit v-1 of `out_sel_oh_o[12k+11:12k]`. A value of 0, or any value in 13..31, gives all zeros.
- R7: When an output's enable bit is 0, its one-hot select is all zeros, whatever the select field holds.
- R8: Bits 0..7 of pointer 0x1D set clamp bits 0..7 of `clamp_mode_o` (inputs 1..8). Bits 0..3 of pointer 0x1E set clamp bits 8..11 (inputs 9..12). Bits 7:4 of 0x1E are ignored. A clamp bit of 1 selects clamp and 0 selects bias.
- R9: Data written to any other pointer (0x00, 0x0A..0x1C, 0x1F..0xFF) is acknowledged and changes no output.
- R10: After each data byte the pointer advances by one, so one transfer can fill several consecutive registers. Each write takes effect as its acknowledge begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| addr_sel_i | input | 1 | Device address select: 0 gives 0x06, 1 gives 0x86 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| out_en_o | output | 9 | Enable of each output |
| out_gain_o | output | 18 | Two-bit gain code of each output |
| out_sel_oh_o | output | 108 | One-hot input selection, 12 bits per output |
| clamp_mode_o | output | 12 | Clamp (1) or bias (0) of each input |

## Verification
A wrong pointer or phase state shows at the ports within one byte. Either the acknowledge on the next ninth clock is missing or unexpected, or a data byte lands in the wrong output or clamp field and stays visible on the decoded outputs once the bus is idle. The bench keeps a behavioural model of the register contents and compares all decoded outputs on every clock while the bus is idle. It also checks each acknowledge bit, so an error in bit counting or address matching appears at the first byte it affects.

// File: rtl/xbar_cfg_pkg.sv
// Shared constants for the crosspoint configuration receiver.
// Assumes 9 <= N_IN <= 16 so the clamp bits fit two register bytes.
package xbar_cfg_pkg;
    localparam int N_IN_DEF     = 12;
    localparam int N_OUT_DEF    = 9;
    localparam int GAIN_W       = 2;
    localparam int SEL_W        = 5;
    localparam int EN_BIT       = 7;
    localparam int GAIN_LSB     = 5;
    localparam int SEL_LSB      = 0;
    localparam logic [6:0] DEV_ADDR7 = 7'h03;
    localparam int ADDR_SEL_BIT = 6;
    localparam logic [7:0] OUT_BASE_PTR = 8'h01;
    localparam logic [7:0] CLAMP_LO_PTR = 8'h1D;
    localparam logic [7:0] CLAMP_HI_PTR = 8'h1E;

    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_SKIP} eng_st_e;
    typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} byte_ph_e;
endpackage

// File: rtl/i2c_pin_sync.sv
// Brings the asynchronous SCL/SDA lines into the clk domain through two
// flops each, then flags SCL edges and START/STOP conditions.
// Assumes clk runs many times faster than SCL.
module i2c_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_prev, sda_prev;

    // Two-stage synchronizers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    // Edge and bus-condition flags from the synchronized lines.
    always_comb begin
        scl_o      = scl_sync[1];
        sda_o      = sda_sync[1];
        scl_rise_o = scl_sync[1] & ~scl_prev;
        scl_fall_o = ~scl_sync[1] & scl_prev;
        start_o    = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
        stop_o     = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
    end
endmodule

// File: rtl/i2c_wr_engine.sv
// Byte engine of the write-only slave: shifts bits on SCL rise, matches the
// address, loads the pointer, issues one write pulse per data byte and
// drives the acknowledge during the ninth clock.
// Assumes synchronized inputs from i2c_pin_sync.
module i2c_wr_engine
    import xbar_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_hi_i,
    input  logic       sda_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       addr_sel_i,
    output logic       sda_pull_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    eng_st_e    st_q;
    byte_ph_e   ph_q;
    logic [3:0] bit_cnt_q;
    logic [7:0] shreg_q;
    logic [7:0] ptr_q;
    logic [7:0] my_addr;
    logic       byte_done;
    logic       addr_hit;

    // Expected address byte for the current select pin, write direction.
    always_comb begin
        my_addr   = {DEV_ADDR7 | (7'(addr_sel_i) << ADDR_SEL_BIT), 1'b0};
        addr_hit  = (shreg_q == my_addr);
        byte_done = (st_q == ST_RX) && scl_fall_i && (bit_cnt_q == 4'd8);
    end

    // Transfer state, bit counter, shift register and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            ph_q      <= PH_ADDR;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            ptr_q     <= '0;
        end else if (start_i) begin
            st_q      <= ST_RX;
            ph_q      <= PH_ADDR;
            bit_cnt_q <= '0;
        end else if (stop_i) begin
            st_q      <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            case (st_q)
                ST_RX: begin
                    if (scl_rise_i) begin
                        shreg_q   <= {shreg_q[6:0], sda_i};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (byte_done) begin
                        st_q <= (ph_q == PH_ADDR && !addr_hit) ? ST_SKIP : ST_ACK;
                        if (ph_q == PH_PTR)  ptr_q <= shreg_q;
                        if (ph_q == PH_DATA) ptr_q <= ptr_q + 8'd1;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        st_q      <= ST_RX;
                        bit_cnt_q <= '0;
                        ph_q      <= (ph_q == PH_ADDR) ? PH_PTR : PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // Acknowledge drive and the single-cycle register write strobe.
    always_comb begin
        sda_pull_o = (st_q == ST_ACK);
        wr_en_o    = byte_done && (ph_q == PH_DATA);
        wr_addr_o  = ptr_q;
        wr_data_o  = shreg_q;
    end

    // R10: the pointer steps by one after every data write.
    a_r10_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (wr_addr_o == $past(wr_addr_o) + 8'd1));
    // R4: a STOP always frees the data line.
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_pull_o);
    // R2: the acknowledge pull starts only while SCL is low.
    a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_hi_i);
endmodule

// File: rtl/xbar_out_decode.sv
// Turns one output's stored enable and select into a one-hot input choice.
// Assumes select values 1..N_IN name inputs and all other values name none.
module xbar_out_decode #(
    parameter int N_IN  = 12,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N_IN-1:0]  sel_oh_o
);
    // One-hot select, forced empty when the output is disabled.
    always_comb begin
        sel_oh_o = '0;
        for (int j = 0; j < N_IN; j++) begin
            if (en_i && (sel_i == SEL_W'(j + 1))) sel_oh_o[j] = 1'b1;
        end
    end

    // R6: never more than one input per output.
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh_o));
    // R7: a disabled output selects nothing.
    a_r7_disabled_none: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (sel_oh_o == '0));
endmodule

// File: rtl/xbar_reg_file.sv
// Control register store for the matrix: one byte per output plus two
// clamp bytes, written by pointer; unknown pointers are dropped.
// Assumes N_OUT outputs start at OUT_BASE_PTR and 9 <= N_IN <= 16.
module xbar_reg_file
    import xbar_cfg_pkg::*;
#(
    parameter int N_IN  = N_IN_DEF,
    parameter int N_OUT = N_OUT_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [7:0]              wr_addr_i,
    input  logic [7:0]              wr_data_i,
    output logic [N_OUT-1:0]        out_en_o,
    output logic [N_OUT*GAIN_W-1:0] out_gain_o,
    output logic [N_OUT*SEL_W-1:0]  out_sel_o,
    output logic [N_IN-1:0]         clamp_o
);
    localparam int HI_W = N_IN - 8;

    logic [7:0]      ctl_q [N_OUT];
    logic [7:0]      clamp_lo_q;
    logic [HI_W-1:0] clamp_hi_q;

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_out
            // Store the control byte of output k on a write to its pointer.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctl_q[k] <= '0;
                else if (wr_en_i && (wr_addr_i == OUT_BASE_PTR + 8'(k)))
                    ctl_q[k] <= wr_data_i;
            end
            assign out_en_o[k] = ctl_q[k][EN_BIT];
            assign out_gain_o[k*GAIN_W +: GAIN_W] = ctl_q[k][GAIN_LSB +: GAIN_W];
            assign out_sel_o[k*SEL_W +: SEL_W]    = ctl_q[k][SEL_LSB +: SEL_W];
        end
    endgenerate

    // Store the clamp bytes; upper bits of the high byte are reserved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_lo_q <= '0;
            clamp_hi_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == CLAMP_LO_PTR) clamp_lo_q <= wr_data_i;
            if (wr_addr_i == CLAMP_HI_PTR) clamp_hi_q <= wr_data_i[HI_W-1:0];
        end
    end

    assign clamp_o = {clamp_hi_q, clamp_lo_q};

    logic known_ptr;
    always_comb begin
        known_ptr = (wr_addr_i >= OUT_BASE_PTR && wr_addr_i < OUT_BASE_PTR + 8'(N_OUT))
                 || (wr_addr_i == CLAMP_LO_PTR) || (wr_addr_i == CLAMP_HI_PTR);
    end

    // R9: writes to unknown pointers change nothing.
    a_r9_unknown_ptr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !known_ptr) |=> $stable({out_en_o, out_gain_o, out_sel_o, clamp_o}));
    // R8: the clamp vector changes only on a clamp pointer write.
    a_r8_clamp_only_by_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_addr_i == CLAMP_LO_PTR || wr_addr_i == CLAMP_HI_PTR))
        |=> $stable(clamp_o));
endmodule

// File: rtl/xbar_cfg_slave.sv
// Top of the write-only configuration receiver for a 12x9 routing matrix:
// bus sampling, byte engine, register store and per-output decode.
// Assumes the bus master never stretches and never reads.
module xbar_cfg_slave
    import xbar_cfg_pkg::*;
#(
    parameter int N_IN  = N_IN_DEF,
    parameter int N_OUT = N_OUT_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_sel_i,
    output logic                    sda_pull_o,
    output logic [N_OUT-1:0]        out_en_o,
    output logic [N_OUT*GAIN_W-1:0] out_gain_o,
    output logic [N_OUT*N_IN-1:0]   out_sel_oh_o,
    output logic [N_IN-1:0]         clamp_mode_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data;
    logic [N_OUT*SEL_W-1:0] out_sel;

    i2c_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    i2c_wr_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_hi_i(scl_s), .sda_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_det),
        .stop_i(stop_det), .addr_sel_i(addr_sel_i), .sda_pull_o(sda_pull_o),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    xbar_reg_file #(.N_IN(N_IN), .N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .out_en_o(out_en_o), .out_gain_o(out_gain_o),
        .out_sel_o(out_sel), .clamp_o(clamp_mode_o)
    );

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_dec
            xbar_out_decode #(.N_IN(N_IN), .SEL_W(SEL_W)) u_dec (
                .clk(clk), .rst_n(rst_n), .en_i(out_en_o[k]),
                .sel_i(out_sel[k*SEL_W +: SEL_W]),
                .sel_oh_o(out_sel_oh_o[k*N_IN +: N_IN])
            );
        end
    endgenerate

    // R3: with no transfer in progress the slave never drives the bus.
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det) |=> !sda_pull_o);
endmodule

// File: tb/xbar_cfg_slave_tb.sv
module xbar_cfg_slave_tb;
    localparam int NI = 12;
    localparam int NO = 9;
    localparam int Q  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1, addr_sel = 1'b0;
    logic sda_line;
    logic sda_pull;
    logic [NO-1:0]    out_en;
    logic [NO*2-1:0]  out_gain;
    logic [NO*NI-1:0] out_sel_oh;
    logic [NI-1:0]    clamp_mode;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit win_bad = 1'b0;

    logic [7:0] m_ctl [NO];
    logic [NI-1:0] m_clamp;
    logic [7:0] tx_q [$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    xbar_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .out_en_o(out_en),
        .out_gain_o(out_gain), .out_sel_oh_o(out_sel_oh), .clamp_mode_o(clamp_mode)
    );

    function automatic logic [NI-1:0] exp_oh(input int k);
        int v;
        logic [NI-1:0] r;
        r = '0;
        v = int'(m_ctl[k][4:0]);
        if (m_ctl[k][7] && v >= 1 && v <= NI) r[v-1] = 1'b1;
        return r;
    endfunction

    function automatic bit state_ok();
        bit ok;
        ok = (clamp_mode == m_clamp);
        for (int k = 0; k < NO; k++) begin
            if (out_en[k] !== m_ctl[k][7]) ok = 0;
            if (out_gain[2*k +: 2] !== m_ctl[k][6:5]) ok = 0;
            if (out_sel_oh[NI*k +: NI] !== exp_oh(k)) ok = 0;
        end
        return ok;
    endfunction

    // Model comparison on every clock while the bus is idle.
    always @(negedge clk) begin
        if (cmp_en && !win_bad && !state_ok()) begin
            win_bad = 1'b1;
            errors++;
            $display("FAIL R5 idle compare: outputs differ from model (en=%h exp_en0=%b)",
                     out_en, m_ctl[0][7]);
        end
    end

    task automatic open_window();
        win_bad = 1'b0;
        checks++;
        cmp_en = 1'b1;
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq();
        scl_drv = 1'b1; wq();
        sda_drv = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq();
            scl_drv = 1'b1; wq(); wq();
            scl_drv = 1'b0; wq();
        end
        sda_drv = 1'b1; wq();
        scl_drv = 1'b1; wq();
        acked = (sda_line == 1'b0);
        wq();
        scl_drv = 1'b0; wq();
    endtask

    function automatic void model_write(input int p, input logic [7:0] d);
        if (p >= 1 && p <= NO) m_ctl[p-1] = d;
        else if (p == 'h1D) m_clamp[7:0] = d;
        else if (p == 'h1E) m_clamp[NI-1:8] = d[NI-9:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs the queued bytes as one transfer and checks each acknowledge.
    task automatic run_xfer(input bit with_start, input bit with_stop, input string tag);
        bit live, got, exp_ack;
        int p;
        logic [7:0] me;
        cmp_en = 1'b0;
        me = addr_sel ? 8'h86 : 8'h06;
        p = 0;
        live = with_start;
        if (with_start) bus_start();
        foreach (tx_q[i]) begin
            send_byte(tx_q[i], got);
            if (i == 0 && live) live = (tx_q[0] == me);
            exp_ack = live;
            if (live && i == 1) p = int'(tx_q[1]);
            if (live && i >= 2) begin
                model_write(p, tx_q[i]);
                p = (p + 1) % 256;
            end
            check(got == exp_ack, $sformatf("%s ack byte %0d", tag, i), got, exp_ack);
        end
        if (with_stop) bus_stop();
        repeat (4 * Q) @(negedge clk);
        check(state_ok(), $sformatf("%s outputs vs model", tag), out_en, m_ctl[0]);
        open_window();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NO; k++) m_ctl[k] = '0;
        m_clamp = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sda_pull == 1'b0, "R1 ack pull after reset", sda_pull, 0);
        check(out_en == '0 && out_gain == '0, "R1 enables/gains after reset", out_en, 0);
        check(out_sel_oh == '0 && clamp_mode == '0, "R1 selects/clamp after reset",
              clamp_mode, 0);
        open_window();

        // R2 R5 R6: single write, addr_sel low
        tx_q = '{8'h06, 8'h01, 8'hA3};
        run_xfer(1, 1, "R2 R5 single write");
        check(out_sel_oh[11:0] == 12'h004, "R6 out0 selects IN3", out_sel_oh[11:0], 12'h004);

        // R10 R7 R6: burst to outputs 1..8 with addr_sel high
        addr_sel = 1'b1;
        repeat (8) @(negedge clk);
        tx_q = '{8'h86, 8'h02, 8'h8C, 8'h8D, 8'h80, 8'hE1, 8'h05, 8'h93, 8'hC7, 8'h9F};
        run_xfer(1, 1, "R10 burst");
        check(out_sel_oh[NI*1 +: NI] == 12'h800, "R6 IN12 on out1", out_sel_oh[NI*1 +: NI], 12'h800);
        check(out_sel_oh[NI*2 +: NI] == 12'h000, "R6 sel 13 gives none",
              out_sel_oh[NI*2 +: NI], 0);
        check(out_sel_oh[NI*5 +: NI] == 12'h000 && out_en[5] == 1'b0,
              "R7 disabled out5 selects none", out_sel_oh[NI*5 +: NI], 0);
        check(out_gain[2*4 +: 2] == 2'b11, "R5 gain 9dB on out4", out_gain[2*4 +: 2], 3);

        // R3: wrong address for the select pin, then R/W = 1
        tx_q = '{8'h06, 8'h01, 8'h00};
        run_xfer(1, 1, "R3 wrong address");
        tx_q = '{8'h87, 8'h01, 8'h00};
        run_xfer(1, 1, "R3 read direction");

        // R8: clamp bytes, reserved upper bits set
        tx_q = '{8'h86, 8'h1D, 8'hA5, 8'hF6};
        run_xfer(1, 1, "R8 clamp");
        check(clamp_mode == 12'h6A5, "R8 clamp vector", clamp_mode, 12'h6A5);

        // R9: unknown pointers, including a run stepping past output 8
        tx_q = '{8'h86, 8'h00, 8'hFF};
        run_xfer(1, 1, "R9 ptr 0x00");
        tx_q = '{8'h86, 8'h09, 8'h81, 8'hFF, 8'hFF};
        run_xfer(1, 1, "R9 run past 0x09");
        tx_q = '{8'h86, 8'h1C, 8'hFF, 8'h1F, 8'h55};
        run_xfer(1, 1, "R9 around clamp regs");
        tx_q = '{8'h86, 8'h40, 8'hFF};
        run_xfer(1, 1, "R9 ptr 0x40");

        // R4: repeated START mid-transfer, then bytes after STOP without START
        tx_q = '{8'h86, 8'h02};
        run_xfer(1, 0, "R4 first half");
        tx_q = '{8'h86, 8'h03, 8'hA2};
        run_xfer(1, 1, "R4 repeated start");
        tx_q = '{8'h86, 8'h03, 8'h00};
        run_xfer(0, 1, "R4 no start");

        // R6: bit 4 of the select set gives none; R7 enable cleared again
        tx_q = '{8'h86, 8'h01, 8'h93, 8'h0C};
        run_xfer(1, 1, "R6 R7 high select");
        check(out_sel_oh[NI*0 +: 2*NI] == '0, "R6 R7 out0/out1 none",
              out_sel_oh[NI*0 +: 2*NI], 0);

        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule